// File: doc/BRIEF.md
# Pipelined Interrupt Aggregation Controller

This block collects interrupt events from eight I/O stages and from a two-level temperature monitor, and drives a single active-low request line towards a host processor. Each stage can report a change of its already filtered input and, when it is configured as an output, an overcurrent. The temperature monitor presents a warning level and a critical level; a rising edge on either one is an event. The temperature events have no enable bits, so they always raise a request.

Captured events wait in a pending queue. The host reads a status word that gives the kind of the oldest pending event. It then reads a source register that names the stages involved. It acknowledges the event by writing an end-of-interrupt bit, and the next queued event then moves to the front. The request line stays low as long as anything is pending. If a stage is switched from input to output mode, everything pending is discarded.

The host reaches the block through a small synchronous register bus. It has a 4-bit address, 8-bit data, and one-cycle read and write strobes. Read data appears one clock after the read strobe.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, `irq_n` is 1, every register reads 0, and nothing is pending.
- R2: A change pulse on `chg_evt` is ANDed with the change-enable register (address 8). A non-zero result makes `irq_n` go to 0 on the second rising edge after the pulse. While that event is at the front, status (address 2) reads bit0=1 and bit6=1, and the change-source register (address 1) reads the gated mask. A pulse on stages whose enable bit is 0 leaves `irq_n` at 1.
- R3: An overcurrent pulse on `ovc_evt` is ANDed with the overcurrent-enable register (address 9) and with the direction register (address 5, 1 = output). While that event is at the front, status reads bit1=1 and bit6=1, the overcurrent-source register (address 3) reads the gated mask, and address 1 reads 0. Overcurrent on input-mode stages is ignored.
- R4: A rising edge of `twarn_lvl` queues a warning event (status bit2). A rising edge of `tcrit_lvl` queues a critical event (status bit3). Neither can be masked. Status bit4 shows the present value of `twarn_lvl` and bit5 the present value of `tcrit_lvl`, whether or not anything is pending.
- R5: A write to address 13 with data bit0=1 removes the front event. If nothing else is pending, `irq_n` returns to 1 on that same edge. Address 13 always reads 0.
- R6: Events are served oldest first. After an acknowledge with more events pending, `irq_n` stays 0 and the registers show the next event.
- R7: When events of several kinds arrive in the same cycle, they are queued in the order critical, warning, overcurrent, change.
- R8: The queue holds DEPTH entries (4 by default). When it is full, further events of one kind are merged by OR into a single held entry, which is queued once space frees. No event is lost.
- R9: An event that arrives in the same cycle as an acknowledge is queued after the acknowledged event is removed.
- R10: A direction write that turns any stage from input (0) to output (1) clears the queue and the held events, and events arriving in that cycle are discarded; `irq_n` is 1 after that edge. A write that only turns stages from output to input clears nothing.
- R11: An acknowledge with nothing pending has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chg_evt | input | 8 | One-cycle change-of-input pulses, one per stage |
| ovc_evt | input | 8 | One-cycle overcurrent pulses, one per stage |
| twarn_lvl | input | 1 | Temperature warning level |
| tcrit_lvl | input | 1 | Temperature critical level |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_rdata | output | 8 | Registered read data |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
An event pulse is registered on the edge where it is sampled. It reaches the queue and drives `irq_n` low on the following edge, so the line is due two edges after the pulse. The bench samples `irq_n` at the falling edge after each of those edges. A read result is due one edge after the strobe, and an acknowledge or a flush takes effect on the edge of its write strobe. A held overflow entry needs one more edge to be queued. For that reason the bench waits at least two idle cycles after each stimulus before it compares queue contents. The only exception is the directed timing check of R2.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int NUM_KINDS = 4;
  // kind codes; a larger code is served first when several arrive together
  localparam int K_CHG   = 0;
  localparam int K_OVC   = 1;
  localparam int K_TWARN = 2;
  localparam int K_TCRIT = 3;
  localparam int KIND_W  = 2;

  localparam int A_CHG_SRC = 1;
  localparam int A_STATUS  = 2;
  localparam int A_OVC_SRC = 3;
  localparam int A_DIR     = 5;
  localparam int A_CHG_EN  = 8;
  localparam int A_OVC_EN  = 9;
  localparam int A_CTRL    = 13;
endpackage

// File: rtl/irq_capture.sv
module irq_capture
  import irq_agg_pkg::*;
#(
  parameter int N = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      chg_evt,
  input  logic [N-1:0]      ovc_evt,
  input  logic              twarn_lvl,
  input  logic              tcrit_lvl,
  input  logic [N-1:0]      chg_en,
  input  logic [N-1:0]      ovc_en,
  input  logic [N-1:0]      dir,
  input  logic              flush,
  input  logic              full,
  output logic              push,
  output logic [KIND_W-1:0] push_kind,
  output logic [N-1:0]      push_mask
);
  logic [N-1:0]         stg_mask [NUM_KINDS];
  logic [NUM_KINDS-1:0] stg_vld;
  logic [N-1:0]         new_mask [NUM_KINDS];
  logic [NUM_KINDS-1:0] new_vld;
  logic                 twarn_q, tcrit_q;
  logic [KIND_W-1:0]    sel;
  logic                 take;

  always_comb begin
    new_mask[K_CHG]   = chg_evt & chg_en;
    new_mask[K_OVC]   = ovc_evt & ovc_en & dir;
    new_mask[K_TWARN] = '0;
    new_mask[K_TCRIT] = '0;
    new_vld[K_CHG]    = |new_mask[K_CHG];
    new_vld[K_OVC]    = |new_mask[K_OVC];
    new_vld[K_TWARN]  = twarn_lvl & ~twarn_q;
    new_vld[K_TCRIT]  = tcrit_lvl & ~tcrit_q;
  end

  // highest pending kind goes first
  always_comb begin
    sel = '0;
    for (int k = 0; k < NUM_KINDS; k++)
      if (stg_vld[k]) sel = KIND_W'(k);
  end

  assign take      = (|stg_vld) && !full && !flush;
  assign push      = take;
  assign push_kind = sel;
  assign push_mask = stg_mask[sel];

  always_ff @(posedge clk) begin
    if (rst) begin
      twarn_q <= 1'b0;
      tcrit_q <= 1'b0;
    end else begin
      twarn_q <= twarn_lvl;
      tcrit_q <= tcrit_lvl;
    end
  end

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst || flush) begin
        stg_mask[k] <= '0;
        stg_vld[k]  <= 1'b0;
      end else if (take && sel == KIND_W'(k)) begin
        stg_mask[k] <= new_mask[k];
        stg_vld[k]  <= new_vld[k];
      end else begin
        stg_mask[k] <= stg_mask[k] | new_mask[k];
        stg_vld[k]  <= stg_vld[k] | new_vld[k];
      end
    end

    AST_HELD_NOT_LOST: assert property (@(posedge clk) disable iff (rst)
      (stg_vld[k] && !(take && sel == KIND_W'(k)) && !flush) |=> stg_vld[k]); // R8
  end

  AST_TEMP_UNMASKED: assert property (@(posedge clk) disable iff (rst)
    (tcrit_lvl && !tcrit_q && !flush) |=> stg_vld[K_TCRIT]); // R4
endmodule

// File: rtl/irq_fifo.sv
module irq_fifo #(
  parameter int W     = 10,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic                       pop,
  input  logic                       flush,
  input  logic [W-1:0]               din,
  output logic [W-1:0]               dout,
  output logic                       empty,
  output logic                       full,
  output logic [$clog2(DEPTH+1)-1:0] cnt_nxt
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign dout    = mem[rd_ptr];

  always_comb begin
    if (flush) cnt_nxt = '0;
    else       cnt_nxt = count + CW'(do_push) - CW'(do_pop);
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      count <= cnt_nxt;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    push |-> !full); // R8
  AST_ACK_ADVANCES: assert property (@(posedge clk) disable iff (rst)
    (pop && !empty && !push && !flush) |=> count == $past(count) - 1'b1); // R5
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_agg_pkg::*;
#(
  parameter int N  = 8,
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DW-1:0]     bus_rdata,
  input  logic              head_valid,
  input  logic [KIND_W-1:0] head_kind,
  input  logic [N-1:0]      head_mask,
  input  logic              twarn_lvl,
  input  logic              tcrit_lvl,
  output logic [N-1:0]      chg_en,
  output logic [N-1:0]      ovc_en,
  output logic [N-1:0]      dir,
  output logic              ack,
  output logic              flush
);
  logic [N-1:0]         wdata_n;
  logic [NUM_KINDS-1:0] kind_hot;
  logic [6:0]           status;
  logic [N-1:0]         chg_src, ovc_src;
  logic                 wr_dir;

  assign wdata_n = bus_wdata[N-1:0];
  assign wr_dir  = bus_wr && bus_addr == AW'(A_DIR);
  assign ack     = bus_wr && bus_addr == AW'(A_CTRL) && bus_wdata[0];
  assign flush   = wr_dir && |(wdata_n & ~dir);

  always_comb begin
    kind_hot = '0;
    if (head_valid) kind_hot[head_kind] = 1'b1;
    status  = {head_valid, tcrit_lvl, twarn_lvl, kind_hot};
    chg_src = kind_hot[K_CHG] ? head_mask : '0;
    ovc_src = kind_hot[K_OVC] ? head_mask : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chg_en <= '0;
      ovc_en <= '0;
      dir    <= '0;
    end else if (bus_wr) begin
      if (bus_addr == AW'(A_CHG_EN)) chg_en <= wdata_n;
      if (bus_addr == AW'(A_OVC_EN)) ovc_en <= wdata_n;
      if (wr_dir)                    dir    <= wdata_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        AW'(A_CHG_SRC): bus_rdata <= DW'(chg_src);
        AW'(A_STATUS):  bus_rdata <= DW'(status);
        AW'(A_OVC_SRC): bus_rdata <= DW'(ovc_src);
        AW'(A_DIR):     bus_rdata <= DW'(dir);
        AW'(A_CHG_EN):  bus_rdata <= DW'(chg_en);
        AW'(A_OVC_EN):  bus_rdata <= DW'(ovc_en);
        default:        bus_rdata <= '0;
      endcase
    end
  end

  AST_CTRL_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == AW'(A_CTRL)) |=> bus_rdata == '0); // R5
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int N     = 8,
  parameter int DEPTH = 4,
  parameter int AW    = 4,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  chg_evt,
  input  logic [N-1:0]  ovc_evt,
  input  logic          twarn_lvl,
  input  logic          tcrit_lvl,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_wr,
  input  logic          bus_rd,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_n
);
  localparam int EW = KIND_W + N;
  localparam int CW = $clog2(DEPTH + 1);

  logic [N-1:0]      chg_en, ovc_en, dir;
  logic              ack, flush, push, empty, full;
  logic [KIND_W-1:0] push_kind;
  logic [N-1:0]      push_mask;
  logic [EW-1:0]     head;
  logic [CW-1:0]     cnt_nxt;

  irq_capture #(.N(N)) u_cap (
    .clk(clk), .rst(rst), .chg_evt(chg_evt), .ovc_evt(ovc_evt),
    .twarn_lvl(twarn_lvl), .tcrit_lvl(tcrit_lvl),
    .chg_en(chg_en), .ovc_en(ovc_en), .dir(dir),
    .flush(flush), .full(full),
    .push(push), .push_kind(push_kind), .push_mask(push_mask)
  );

  irq_fifo #(.W(EW), .DEPTH(DEPTH)) u_q (
    .clk(clk), .rst(rst), .push(push), .pop(ack), .flush(flush),
    .din({push_kind, push_mask}), .dout(head),
    .empty(empty), .full(full), .cnt_nxt(cnt_nxt)
  );

  irq_regs #(.N(N), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .head_valid(!empty), .head_kind(head[EW-1:N]), .head_mask(head[N-1:0]),
    .twarn_lvl(twarn_lvl), .tcrit_lvl(tcrit_lvl),
    .chg_en(chg_en), .ovc_en(ovc_en), .dir(dir),
    .ack(ack), .flush(flush)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b1;
    else     irq_n <= (cnt_nxt == '0);
  end

  AST_FLUSH_RELEASES: assert property (@(posedge clk) disable iff (rst)
    flush |=> irq_n); // R10
  AST_PUSH_LOWERS_LINE: assert property (@(posedge clk) disable iff (rst)
    (push && !full && !flush) |=> !irq_n); // R2
endmodule

// File: tb/sim_irq_aggregator.sv
`timescale 1ns/1ps
module sim_irq_aggregator;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] chg_evt = '0, ovc_evt = '0;
  logic       twarn_lvl = 1'b0, tcrit_lvl = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic       irq_n;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_aggregator u0 (
    .clk(clk), .rst(rst), .chg_evt(chg_evt), .ovc_evt(ovc_evt),
    .twarn_lvl(twarn_lvl), .tcrit_lvl(tcrit_lvl),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq_n(irq_n)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse_chg(logic [7:0] m);
    chg_evt = m;
    @(negedge clk);
    chg_evt = '0;
  endtask

  task automatic pulse_ovc(logic [7:0] m);
    ovc_evt = m;
    @(negedge clk);
    ovc_evt = '0;
  endtask

  task automatic eoi();
    wr(4'd13, 8'h01);
    idle(2);
  endtask

  task automatic expect_reg(string req, logic [3:0] a, logic [7:0] e);
    logic [7:0] v;
    rd(a, v);
    chk(req, v, e);
  endtask

  // reference model of the pending change events for the random phase
  function automatic logic [7:0] gated(logic [7:0] evt, logic [7:0] en);
    return evt & en;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] q[$];
    logic [7:0] held;
    logic [7:0] en;
    logic [7:0] v;
    void'($urandom(32'd20240611));
    idle(3);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq_n", irq_n, 1);
    expect_reg("R1 status", 4'd2, 8'h00);
    expect_reg("R1 chg_en", 4'd8, 8'h00);
    expect_reg("R1 dir", 4'd5, 8'h00);

    // R2 masking and timing
    wr(4'd8, 8'h0F);
    pulse_chg(8'hF0);
    idle(3);
    chk("R2 masked stages ignored", irq_n, 1);
    pulse_chg(8'h3C);
    chk("R2 line not yet low", irq_n, 1);
    @(negedge clk);
    chk("R2 line low second edge", irq_n, 0);
    expect_reg("R2 status", 4'd2, 8'h41);
    expect_reg("R2 change source", 4'd1, 8'h0C);
    expect_reg("R2 ovc source zero", 4'd3, 8'h00);
    wr(4'd13, 8'h01);
    chk("R5 line released by ack", irq_n, 1);
    expect_reg("R5 ctrl reads zero", 4'd13, 8'h00);

    // R3 overcurrent gated by enable and output mode
    wr(4'd9, 8'hFF);
    pulse_ovc(8'h01);
    idle(3);
    chk("R3 input-mode overcurrent ignored", irq_n, 1);
    wr(4'd5, 8'h03);
    wr(4'd9, 8'h02);
    pulse_ovc(8'h03);
    idle(2);
    chk("R3 line low", irq_n, 0);
    expect_reg("R3 status", 4'd2, 8'h42);
    expect_reg("R3 ovc source", 4'd3, 8'h02);
    expect_reg("R3 change source zero", 4'd1, 8'h00);
    eoi();

    // R4 temperature, unmaskable
    wr(4'd8, 8'h00);
    wr(4'd9, 8'h00);
    twarn_lvl = 1'b1;
    idle(3);
    chk("R4 warning raises line", irq_n, 0);
    expect_reg("R4 warning status", 4'd2, 8'h54);
    eoi();
    expect_reg("R4 live warning level", 4'd2, 8'h10);
    tcrit_lvl = 1'b1;
    idle(3);
    expect_reg("R4 critical status", 4'd2, 8'h78);
    eoi();
    twarn_lvl = 1'b0; tcrit_lvl = 1'b0;
    idle(2);
    expect_reg("R4 levels low", 4'd2, 8'h00);

    // R7 same-cycle priority, R6 order
    wr(4'd8, 8'hFF);
    wr(4'd9, 8'hFF);
    wr(4'd5, 8'hFF);
    chg_evt = 8'h01; ovc_evt = 8'h80; twarn_lvl = 1'b1; tcrit_lvl = 1'b1;
    @(negedge clk);
    chg_evt = '0; ovc_evt = '0;
    idle(5);
    expect_reg("R7 critical first", 4'd2, 8'h78);
    eoi();
    chk("R6 line stays low", irq_n, 0);
    expect_reg("R7 warning second", 4'd2, 8'h74);
    eoi();
    expect_reg("R7 overcurrent third", 4'd2, 8'h72);
    expect_reg("R7 overcurrent stage", 4'd3, 8'h80);
    eoi();
    expect_reg("R7 change last", 4'd2, 8'h71);
    expect_reg("R7 change stage", 4'd1, 8'h01);
    eoi();
    chk("R6 line released when drained", irq_n, 1);
    twarn_lvl = 1'b0; tcrit_lvl = 1'b0;
    idle(2);

    // R8 overflow merge
    pulse_chg(8'h01); idle(1);
    pulse_chg(8'h02); idle(1);
    pulse_chg(8'h04); idle(1);
    pulse_chg(8'h08); idle(1);
    pulse_chg(8'h10); idle(1);
    pulse_chg(8'h20); idle(2);
    expect_reg("R8 head 1", 4'd1, 8'h01); eoi();
    expect_reg("R8 head 2", 4'd1, 8'h02); eoi();
    expect_reg("R8 head 3", 4'd1, 8'h04); eoi();
    expect_reg("R8 head 4", 4'd1, 8'h08); eoi();
    expect_reg("R8 merged held entry", 4'd1, 8'h30); eoi();
    chk("R8 drained", irq_n, 1);

    // R9 event in the acknowledge cycle
    pulse_chg(8'h01);
    idle(2);
    bus_addr = 4'd13; bus_wdata = 8'h01; bus_wr = 1'b1; chg_evt = 8'h40;
    @(negedge clk);
    bus_wr = 1'b0; chg_evt = '0;
    idle(3);
    chk("R9 line low after ack", irq_n, 0);
    expect_reg("R9 event kept", 4'd1, 8'h40);
    eoi();

    // R10 direction flush
    pulse_chg(8'h05);
    idle(3);
    wr(4'd5, 8'h7F);
    chk("R10 output-to-input keeps queue", irq_n, 0);
    expect_reg("R10 entry kept", 4'd1, 8'h05);
    wr(4'd5, 8'hFF);
    chk("R10 flush releases line", irq_n, 1);
    idle(2);
    expect_reg("R10 status cleared", 4'd2, 8'h00);

    // R11 ack on empty queue
    wr(4'd13, 8'h01);
    idle(2);
    chk("R11 line idle", irq_n, 1);
    expect_reg("R11 status idle", 4'd2, 8'h00);
    pulse_chg(8'h02);
    idle(3);
    expect_reg("R11 later event served", 4'd1, 8'h02);
    eoi();

    // random phase, R6 and R8
    held = '0;
    en = 8'hFF;
    for (int i = 0; i < 400; i++) begin
      int act;
      act = $urandom_range(0, 9);
      if (act < 5) begin
        logic [7:0] m, g;
        m = 8'($urandom);
        g = gated(m, en);
        pulse_chg(m);
        if (g != 0) begin
          if (q.size() < 4) q.push_back(g);
          else held |= g;
        end
      end else if (act < 9) begin
        wr(4'd13, 8'h01);
        if (q.size() > 0) void'(q.pop_front());
        if (held != 0 && q.size() < 4) begin
          q.push_back(held);
          held = '0;
        end
      end else begin
        en = 8'($urandom);
        wr(4'd8, en);
      end
      idle(3);
      chk("R6 random irq_n", irq_n, (q.size() == 0) ? 1 : 0);
      rd(4'd1, v);
      chk("R8 random head", v, (q.size() == 0) ? 0 : q[0]);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule